// File: doc/BRIEF.md
# Block-Committed Transmit Buffer with Priority Byte

This block is the transmit-side staging logic of an asynchronous serial channel. Software loads up to 32 bytes into a pool by writing each byte at an offset within a window. The bytes stay in the pool until software issues a transmit command. The block then hands the bytes to a downstream serializer in offset order, one at a time, over a byte/valid/ready handshake. A command-busy flag covers the short interval in which a command is being taken up.

A separate one-byte priority register lets software push a single urgent character, such as a flow-control byte, ahead of whatever remains in the pool. The priority byte goes out at the next character boundary and never interrupts a character that has already been offered. A busy flag tells software when the register may be written again.

Three status outputs report the transmit path:
- a write-enable status shows when the pool may be loaded;
- a pool-ready event marks the moment a block has fully drained;
- an all-sent status and event report that nothing is queued and the serializer has gone idle.

A reset command empties the pool. A break control level stops new characters from being offered and is passed on to the line driver.

Top module: `txblk_fifo`

## Requirements
- R1: After reset `pool_wen`=1, `cmd_busy`=0, `imm_busy`=0, `ser_valid`=0, `ser_brk`=0, and `all_sent`=1 while `ser_idle`=1.
- R2: A pool write (`wr_en`) is stored only while `pool_wen`=1. Writes made while a command is busy or a block is being sent change neither the bytes nor the length of that block.
- R3: On a transmit command the block sends exactly L bytes, where L is one plus the highest offset written since the previous block ended. The bytes go out in rising offset order, and a rewritten offset carries its last written value.
- R4: An accepted `cmd_xmit` raises `cmd_busy` in the next cycle for `CMD_LAT` cycles and lowers `pool_wen`. Sending starts when `cmd_busy` falls. A command is ignored while `cmd_busy` is high, while a block is being sent, or while the pool length is zero.
- R5: `ev_pool_rdy` is a one-cycle pulse in the cycle after the last pool byte is handshaked. `pool_wen` is 1 in that same cycle and the pool length returns to zero.
- R6: `all_sent` is 1 only when no command is busy, no block is being sent, no byte is offered, no priority byte is pending and `ser_idle`=1. `ev_all_sent` pulses for one cycle when `all_sent` rises.
- R7: Writing `imm_data` with `imm_wr` while `imm_busy`=0 sets `imm_busy` on the next cycle. That byte is the next byte offered after the current handshake, ahead of any remaining pool bytes. `imm_busy` clears after its handshake. A write while `imm_busy`=1 is ignored.
- R8: Once `ser_valid` is 1 it stays 1 with `ser_data` unchanged until a cycle with `ser_ready`=1.
- R9: `cmd_xres` empties the pool and cancels a busy command or a block being sent. In the next cycle `pool_wen`=1 and `cmd_busy`=0. No further pool byte is offered, and a following command with no new writes is ignored.
- R10: `ser_brk` equals `brk_ctl` delayed by one cycle. While `brk_ctl`=1 no new byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pool byte write strobe |
| wr_addr | input | AW (5) | Offset of the byte within the pool window |
| wr_data | input | DW (8) | Pool byte value |
| cmd_xmit | input | 1 | Transmit command pulse |
| cmd_xres | input | 1 | Transmit reset command pulse |
| imm_wr | input | 1 | Priority byte write strobe |
| imm_data | input | DW (8) | Priority byte value |
| brk_ctl | input | 1 | Break control level |
| ser_valid | output | 1 | Byte offered to the serializer |
| ser_data | output | DW (8) | Offered byte |
| ser_ready | input | 1 | Serializer accepts the offered byte |
| ser_idle | input | 1 | Serializer has no bits left to shift |
| ser_brk | output | 1 | Break request to the line driver |
| pool_wen | output | 1 | Pool may be loaded |
| cmd_busy | output | 1 | A transmit command is being taken up |
| imm_busy | output | 1 | Priority byte still pending |
| all_sent | output | 1 | Nothing queued and serializer idle |
| ev_pool_rdy | output | 1 | One-cycle pulse: pool drained |
| ev_all_sent | output | 1 | One-cycle pulse: all_sent rose |

## Verification
Blocks are sent with a short run of in-order writes, a full 32-byte load written backwards with one offset rewritten, and a single-byte load. Together these separate offset-ordered reading from write-order reading and show that the length comes from the highest offset written. The serializer's ready is random for most blocks. It is held low when a priority byte is injected behind an offered pool byte, which tells a correct insertion at the character boundary apart from a split character or a byte dropped from the pool. Writes and commands issued during busy or sending phases, a reset command during the busy window, and a break held across a command show whether each gate blocks what it should.

// File: rtl/txb_pkg.sv
package txb_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_POOL = 2'd1,
    SRC_IMM  = 2'd2
  } src_e;

  // Block length after a write at offset off: the highest written offset plus one.
  function automatic int unsigned blk_len_after(int unsigned cur, int unsigned off);
    if (off + 1 > cur) return off + 1;
    return cur;
  endfunction

  // True while the pool still holds unsent bytes of the current block.
  function automatic logic pool_has_more(int unsigned rd, int unsigned len);
    return rd < len;
  endfunction

endpackage

// File: rtl/txb_pool.sv
module txb_pool #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          clr,
  input  logic [LW-1:0] rd_ptr,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] blk_len
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      blk_len <= '0;
    else if (clr)    blk_len <= '0;
    else if (wr_acc) blk_len <= LW'(txb_pkg::blk_len_after(int'(blk_len), int'(wr_addr)));
  end

  assign rd_data = mem[rd_ptr[AW-1:0]];

endmodule

// File: rtl/txb_ctrl.sv
module txb_ctrl #(
  parameter int DEPTH   = 32,
  parameter int CMD_LAT = 2,
  localparam int LW     = $clog2(DEPTH + 1),
  localparam int CW     = $clog2(CMD_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_xmit,
  input  logic          cmd_xres,
  input  logic [LW-1:0] blk_len,
  input  logic          pool_load,
  input  logic          pool_hs,
  output logic [LW-1:0] rd_ptr,
  output logic          sending,
  output logic          cmd_busy,
  output logic          pool_wen,
  output logic          pool_avail,
  output logic          blk_done,
  output logic          pool_clr,
  output logic          ev_pool_rdy
);

  logic [CW-1:0] busy_cnt;
  logic          start_ok;

  assign cmd_busy   = (busy_cnt != '0);
  assign pool_wen   = !cmd_busy && !sending;
  assign start_ok   = cmd_xmit && !cmd_busy && !sending && (blk_len != '0);
  assign pool_avail = sending && txb_pkg::pool_has_more(int'(rd_ptr), int'(blk_len));
  assign blk_done   = pool_hs && sending && (rd_ptr == blk_len);
  assign pool_clr   = cmd_xres || blk_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      sending  <= 1'b0;
      rd_ptr   <= '0;
    end else if (cmd_xres) begin
      busy_cnt <= '0;
      sending  <= 1'b0;
      rd_ptr   <= '0;
    end else begin
      if (start_ok)              busy_cnt <= CW'(CMD_LAT);
      else if (busy_cnt != '0)   busy_cnt <= busy_cnt - CW'(1);
      if (busy_cnt == CW'(1)) begin
        sending <= 1'b1;
        rd_ptr  <= '0;
      end else begin
        if (pool_load) rd_ptr  <= rd_ptr + LW'(1);
        if (blk_done)  sending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ev_pool_rdy <= 1'b0;
    else        ev_pool_rdy <= blk_done && !cmd_xres;
  end

endmodule

// File: rtl/txb_out.sv
module txb_out #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          imm_wr,
  input  logic [DW-1:0] imm_data,
  input  logic          brk_ctl,
  input  logic          pool_avail,
  input  logic [DW-1:0] pool_data,
  input  logic          ser_ready,
  output logic          pool_load,
  output logic          pool_hs,
  output logic          ser_valid,
  output logic [DW-1:0] ser_data,
  output logic          imm_busy,
  output logic          ser_brk,
  output logic          src_imm
);

  import txb_pkg::*;

  src_e          out_src;
  logic          imm_pend;
  logic [DW-1:0] imm_byte;
  logic          hs, can_load, load_imm, imm_hs;

  assign hs        = ser_valid && ser_ready;
  assign can_load  = !ser_valid && !brk_ctl;
  assign load_imm  = can_load && imm_pend;
  assign pool_load = can_load && !imm_pend && pool_avail;
  assign pool_hs   = hs && (out_src == SRC_POOL);
  assign imm_hs    = hs && (out_src == SRC_IMM);
  assign imm_busy  = imm_pend;
  assign src_imm   = (out_src == SRC_IMM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_valid <= 1'b0;
      ser_data  <= '0;
      out_src   <= SRC_NONE;
    end else if (hs) begin
      ser_valid <= 1'b0;
      out_src   <= SRC_NONE;
    end else if (load_imm) begin
      ser_valid <= 1'b1;
      ser_data  <= imm_byte;
      out_src   <= SRC_IMM;
    end else if (pool_load) begin
      ser_valid <= 1'b1;
      ser_data  <= pool_data;
      out_src   <= SRC_POOL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imm_pend <= 1'b0;
      imm_byte <= '0;
    end else if (imm_hs) begin
      imm_pend <= 1'b0;
    end else if (imm_wr && !imm_pend) begin
      imm_pend <= 1'b1;
      imm_byte <= imm_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ser_brk <= 1'b0;
    else        ser_brk <= brk_ctl;
  end

endmodule

// File: rtl/txblk_fifo.sv
module txblk_fifo #(
  parameter int DEPTH   = 32,
  parameter int DW      = 8,
  parameter int CMD_LAT = 2,
  localparam int AW     = $clog2(DEPTH),
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cmd_xmit,
  input  logic          cmd_xres,
  input  logic          imm_wr,
  input  logic [DW-1:0] imm_data,
  input  logic          brk_ctl,
  output logic          ser_valid,
  output logic [DW-1:0] ser_data,
  input  logic          ser_ready,
  input  logic          ser_idle,
  output logic          ser_brk,
  output logic          pool_wen,
  output logic          cmd_busy,
  output logic          imm_busy,
  output logic          all_sent,
  output logic          ev_pool_rdy,
  output logic          ev_all_sent
);

  // Internal events brought out as named wires for the checker.
  logic          wr_acc;
  logic          pool_clr;
  logic          pool_load;
  logic          pool_hs;
  logic          pool_avail;
  logic          blk_done;
  logic          sending;
  logic          src_imm;
  logic [LW-1:0] rd_ptr;
  logic [LW-1:0] blk_len;
  logic [DW-1:0] pool_rdata;
  logic          all_q;

  assign wr_acc = wr_en && pool_wen;

  txb_pool #(.DEPTH(DEPTH), .DW(DW)) u_pool (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_acc  (wr_acc),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .clr     (pool_clr),
    .rd_ptr  (rd_ptr),
    .rd_data (pool_rdata),
    .blk_len (blk_len)
  );

  txb_ctrl #(.DEPTH(DEPTH), .CMD_LAT(CMD_LAT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_xmit    (cmd_xmit),
    .cmd_xres    (cmd_xres),
    .blk_len     (blk_len),
    .pool_load   (pool_load),
    .pool_hs     (pool_hs),
    .rd_ptr      (rd_ptr),
    .sending     (sending),
    .cmd_busy    (cmd_busy),
    .pool_wen    (pool_wen),
    .pool_avail  (pool_avail),
    .blk_done    (blk_done),
    .pool_clr    (pool_clr),
    .ev_pool_rdy (ev_pool_rdy)
  );

  txb_out #(.DW(DW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .imm_wr     (imm_wr),
    .imm_data   (imm_data),
    .brk_ctl    (brk_ctl),
    .pool_avail (pool_avail),
    .pool_data  (pool_rdata),
    .ser_ready  (ser_ready),
    .pool_load  (pool_load),
    .pool_hs    (pool_hs),
    .ser_valid  (ser_valid),
    .ser_data   (ser_data),
    .imm_busy   (imm_busy),
    .ser_brk    (ser_brk),
    .src_imm    (src_imm)
  );

  assign all_sent = !sending && !cmd_busy && !ser_valid && !imm_busy && ser_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) all_q <= 1'b1;
    else        all_q <= all_sent;
  end

  assign ev_all_sent = all_sent && !all_q;

endmodule

// File: rtl/txb_chk.sv
module txb_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_valid,
  input logic          ser_ready,
  input logic [DW-1:0] ser_data,
  input logic          cmd_busy,
  input logic          cmd_xres,
  input logic          sending,
  input logic          pool_wen,
  input logic          ev_pool_rdy,
  input logic          ev_all_sent,
  input logic          imm_busy,
  input logic          src_imm,
  input logic          brk_ctl,
  input logic          ser_brk
);

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid && !ser_ready |=> ser_valid && $stable(ser_data)); // R8

  AST_BUSY_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy && !cmd_xres |=> cmd_busy || sending); // R4

  AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pool_rdy |=> !ev_pool_rdy); // R5

  AST_RDY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pool_rdy |-> pool_wen); // R5

  AST_ALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_all_sent |=> !ev_all_sent); // R6

  AST_IMM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    imm_busy && !ser_valid && !brk_ctl |=> ser_valid && src_imm); // R7

  AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ctl && !ser_valid |=> !ser_valid); // R10

  AST_BRK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ctl |=> ser_brk); // R10

  AST_XRES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_xres |=> pool_wen && !cmd_busy); // R9

endmodule

bind txblk_fifo txb_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ser_valid   (ser_valid),
  .ser_ready   (ser_ready),
  .ser_data    (ser_data),
  .cmd_busy    (cmd_busy),
  .cmd_xres    (cmd_xres),
  .sending     (sending),
  .pool_wen    (pool_wen),
  .ev_pool_rdy (ev_pool_rdy),
  .ev_all_sent (ev_all_sent),
  .imm_busy    (imm_busy),
  .src_imm     (src_imm),
  .brk_ctl     (brk_ctl),
  .ser_brk     (ser_brk)
);

// File: tb/txblk_fifo_tb.sv
module txblk_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int DW = 8;
  localparam int CMD_LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, cmd_xmit = 1'b0, cmd_xres = 1'b0, imm_wr = 1'b0, brk_ctl = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0, imm_data = '0;
  logic ser_ready = 1'b0, ser_idle = 1'b1;
  logic ser_valid, ser_brk, pool_wen, cmd_busy, imm_busy, all_sent, ev_pool_rdy, ev_all_sent;
  logic [DW-1:0] ser_data;

  txblk_fifo #(.DEPTH(DEPTH), .DW(DW), .CMD_LAT(CMD_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_xmit(cmd_xmit), .cmd_xres(cmd_xres), .imm_wr(imm_wr), .imm_data(imm_data),
    .brk_ctl(brk_ctl), .ser_valid(ser_valid), .ser_data(ser_data), .ser_ready(ser_ready),
    .ser_idle(ser_idle), .ser_brk(ser_brk), .pool_wen(pool_wen), .cmd_busy(cmd_busy),
    .imm_busy(imm_busy), .all_sent(all_sent), .ev_pool_rdy(ev_pool_rdy), .ev_all_sent(ev_all_sent)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, n_rdy = 0, n_all = 0, wd = 0, idle_cnt = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] img [DEPTH];
  logic [7:0] lfsr = 8'h5B;
  bit rdy_en = 1'b0, hs_flag = 1'b0;
  string cur_req = "R3";

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // Monitor: scoreboard pop and event counting, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_valid && ser_ready) begin
        if (exp_q.size() == 0) check(1'b0, {cur_req, " unexpected byte"}, int'(ser_data), 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(ser_data == e, {cur_req, " byte order"}, int'(ser_data), int'(e));
        end
        hs_flag = 1'b1;
      end
      if (ev_pool_rdy) begin
        n_rdy++;
        check(pool_wen == 1'b1, "R5 pool_wen with ev_pool_rdy", int'(pool_wen), 1);
      end
      if (ev_all_sent) n_all++;
    end
  end

  // Serializer model: random ready, idle a few cycles after each byte.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ser_ready = rdy_en & lfsr[0];
    if (hs_flag) begin idle_cnt = 4; hs_flag = 1'b0; end
    else if (idle_cnt > 0) idle_cnt--;
    ser_idle = (idle_cnt == 0);
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(int a, logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic cmd_go(int push_len);
    for (int i = 0; i < push_len; i++) exp_q.push_back(img[i]);
    cmd_xmit = 1'b1;
    tick();
    cmd_xmit = 1'b0;
  endtask

  task automatic wait_rdy(int target, string req);
    int n;
    n = 0;
    while (n_rdy < target && n < 3000) begin @(negedge clk); n++; end
    check(n_rdy >= target, {req, " block drained"}, n_rdy, target);
    tick();
  endtask

  initial begin
    int base;
    logic stable_ok;
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pool_wen == 1'b1, "R1 pool_wen", int'(pool_wen), 1);
    check(cmd_busy == 1'b0, "R1 cmd_busy", int'(cmd_busy), 0);
    check(imm_busy == 1'b0, "R1 imm_busy", int'(imm_busy), 0);
    check(ser_valid == 1'b0, "R1 ser_valid", int'(ser_valid), 0);
    check(all_sent == 1'b1, "R1 all_sent", int'(all_sent), 1);
    check(ser_brk == 1'b0, "R1 ser_brk", int'(ser_brk), 0);
    tick();
    rdy_en = 1'b1;

    // R3/R4: short block in order
    cur_req = "R3";
    for (int i = 0; i < 5; i++) begin img[i] = 8'(8'h10 + i); wr(i, img[i]); end
    cmd_go(5);
    @(negedge clk);
    check(cmd_busy == 1'b1, "R4 cmd_busy after command", int'(cmd_busy), 1);
    check(pool_wen == 1'b0, "R4 pool_wen after command", int'(pool_wen), 0);
    check(all_sent == 1'b0, "R6 all_sent while busy", int'(all_sent), 0);
    tick();
    wait_rdy(1, "R3");
    check(exp_q.size() == 0, "R3 short block complete", exp_q.size(), 0);

    // R3: full pool written backwards, one offset rewritten
    for (int i = DEPTH - 1; i >= 0; i--) begin img[i] = 8'(i * 7 + 3); wr(i, img[i]); end
    img[5] = 8'hA5; wr(5, 8'hA5);
    cmd_go(DEPTH);
    wait_rdy(2, "R3");
    check(exp_q.size() == 0, "R3 full block complete", exp_q.size(), 0);

    // R2: writes during busy and sending are ignored
    cur_req = "R2";
    for (int i = 0; i < 3; i++) begin img[i] = 8'(8'h60 + i); wr(i, img[i]); end
    cmd_go(3);
    wr(0, 8'hEE);
    repeat (3) tick();
    wr(6, 8'hEF);
    wait_rdy(3, "R2");
    check(exp_q.size() == 0, "R2 block unchanged by late writes", exp_q.size(), 0);
    img[0] = 8'h5A; wr(0, 8'h5A);
    cmd_go(1);
    wait_rdy(4, "R2");
    check(exp_q.size() == 0, "R2 single-byte block", exp_q.size(), 0);

    // R4: empty command ignored, repeated command ignored
    cur_req = "R4";
    cmd_go(0);
    @(negedge clk);
    check(cmd_busy == 1'b0, "R4 empty command ignored", int'(cmd_busy), 0);
    tick();
    img[0] = 8'h31; wr(0, 8'h31); img[1] = 8'h32; wr(1, 8'h32);
    cmd_go(2);
    cmd_go(0);
    wait_rdy(5, "R4");
    repeat (20) tick();
    check(n_rdy == 5, "R4 second command ignored", n_rdy, 5);
    check(exp_q.size() == 0, "R4 queue empty", exp_q.size(), 0);

    // R7/R8: priority byte behind a held pool byte
    cur_req = "R7";
    rdy_en = 1'b0;
    tick();
    for (int i = 0; i < 4; i++) begin img[i] = 8'(8'h80 + i); wr(i, img[i]); end
    cmd_go(0);
    repeat (4) tick();
    imm_wr = 1'b1; imm_data = 8'hC3; tick();
    imm_data = 8'h3C; tick();
    imm_wr = 1'b0;
    @(negedge clk);
    check(imm_busy == 1'b1, "R7 imm_busy set", int'(imm_busy), 1);
    stable_ok = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!(ser_valid && ser_data == img[0])) stable_ok = 1'b0;
    end
    check(stable_ok, "R8 held byte stable", int'(ser_data), int'(img[0]));
    exp_q.push_back(img[0]); exp_q.push_back(8'hC3);
    for (int i = 1; i < 4; i++) exp_q.push_back(img[i]);
    tick();
    rdy_en = 1'b1;
    wait_rdy(6, "R7");
    check(exp_q.size() == 0, "R7 priority order", exp_q.size(), 0);
    check(imm_busy == 1'b0, "R7 imm_busy cleared", int'(imm_busy), 0);
    exp_q.push_back(8'h77);
    imm_wr = 1'b1; imm_data = 8'h77; tick(); imm_wr = 1'b0;
    repeat (40) tick();
    check(exp_q.size() == 0, "R7 lone priority byte sent", exp_q.size(), 0);
    check(imm_busy == 1'b0, "R7 imm_busy after lone byte", int'(imm_busy), 0);

    // R6: all-sent once per drained block
    cur_req = "R6";
    base = n_all;
    for (int i = 0; i < 3; i++) begin img[i] = 8'(8'hB0 + i); wr(i, img[i]); end
    cmd_go(3);
    wait_rdy(7, "R6");
    repeat (12) tick();
    @(negedge clk);
    check(all_sent == 1'b1, "R6 all_sent after drain", int'(all_sent), 1);
    check(n_all - base == 1, "R6 one all-sent event", n_all - base, 1);
    tick();

    // R10: break holds the line
    cur_req = "R10";
    brk_ctl = 1'b1;
    tick();
    @(negedge clk);
    check(ser_brk == 1'b1, "R10 ser_brk follows", int'(ser_brk), 1);
    tick();
    img[0] = 8'hD1; wr(0, 8'hD1); img[1] = 8'hD2; wr(1, 8'hD2);
    cmd_go(2);
    stable_ok = 1'b1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (ser_valid) stable_ok = 1'b0; end
    check(stable_ok, "R10 no byte during break", int'(ser_valid), 0);
    tick();
    brk_ctl = 1'b0;
    wait_rdy(8, "R10");
    @(negedge clk);
    check(ser_brk == 1'b0, "R10 ser_brk released", int'(ser_brk), 0);
    check(exp_q.size() == 0, "R10 block after break", exp_q.size(), 0);
    tick();

    // R9: reset command during busy window
    cur_req = "R9";
    for (int i = 0; i < 3; i++) begin img[i] = 8'(8'hE0 + i); wr(i, img[i]); end
    cmd_go(0);
    cmd_xres = 1'b1; tick(); cmd_xres = 1'b0;
    @(negedge clk);
    check(pool_wen == 1'b1, "R9 pool_wen after reset cmd", int'(pool_wen), 1);
    check(cmd_busy == 1'b0, "R9 cmd_busy after reset cmd", int'(cmd_busy), 0);
    stable_ok = 1'b1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (ser_valid) stable_ok = 1'b0; end
    check(stable_ok, "R9 no byte after reset cmd", int'(ser_valid), 0);
    tick();
    cmd_go(0);
    @(negedge clk);
    check(cmd_busy == 1'b0, "R9 command on emptied pool ignored", int'(cmd_busy), 0);
    check(n_rdy == 8, "R9 no pool-ready event", n_rdy, 8);

    summary();
    $finish;
  end

endmodule